// File: doc/BRIEF.md
# CRT Controller Register Emulator

This block is the register front end of a character display that can behave like either a monochrome text adapter or a colour adapter. It sits on a byte-wide I/O bus. The bus has two port groups, one for monochrome and one for colour. Each group offers an index port, a data port, a mode-control port, a status port and a colour-select port. The block holds only the few controller registers that a flat panel needs: cursor start line, cursor end line, display start address high byte, and the two bytes of the cursor location. Every other register index accepts a write and discards it.

Writes are adjusted to suit the active emulation. In monochrome mode the panel's cells are 8 lines tall, so the cursor line numbers written for a 14-line cell are rescaled into 0 to 7. In colour text mode the display start address is forced onto page boundaries. In monochrome mode and in any graphics mode it is held at zero. The status port does not follow any real retrace. Instead, two of its bits flip on every read, so that polling software always sees a change. The block comes out of reset in monochrome mode with video disabled. It drives the stored register values and the mode flags to the cursor and panel logic.

Top module: `crtc_reg_emu`

## Requirements
- R1: After reset the block is in monochrome mode, video_en is 0, the 80-column and graphics flags are 0, and every stored register and the status toggle are 0.
- R2: Port decode uses io_addr[3] as the group (0 monochrome, 1 colour) and io_addr[2:0] as the port (0 index, 1 data, 2 mode control, 3 status, 4 colour select). A write to the mode-control port of a group makes that group's emulation active.
- R3: In monochrome mode, a line number v = data[4:0] written to register 10 or 11 is stored as 0 for v in 0–1, 1 for 2–3, 2 for 4–5, 3 for 6–7, 4 for 8–9, 5 for 10–11, 6 for 12, and 7 for 13 and above. Register 10 also keeps data bits 6:5 in its bits 6:5.
- R4: In colour mode, register 10 stores data[6:0] unchanged and register 11 stores data[4:0] unchanged.
- R5: In colour 80-column text mode (mode bit 0 = 1, bit 1 = 0), register 12 keeps only data & 30h. An already stored value is reduced to value & 30h when this mode becomes active.
- R6: In colour 40-column text mode (mode bits 1:0 = 00), register 12 keeps only data & 38h.
- R7: In monochrome mode and in graphics mode (mode bit 1 = 1), writes to register 12 are ignored and register 12 reads 00h. Entering either mode clears it.
- R8: Each read of the status port returns 00h or 09h (bits 0 and 3 equal, all others 0). The two bits flip after every status read.
- R9: Writes to register indices other than 10, 11, 12, 14 and 15 change nothing, and reading such an index through the data port returns 00h.
- R10: Mode-control bit 3 drives video_en. Bit 2 is ignored and reads back 0. The mode port reads back the stored byte with bit 2 cleared. Writes to the colour-select port have no effect.
- R11: Register 14 stores data[5:0] and register 15 stores data[7:0] in either mode. They form cur_loc = {reg14, reg15}, and reads return them zero-extended.
- R12: A read returns its data on io_rdata one clock after the read strobe. The index port reads back the stored index zero-extended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 4 | Group bit and port offset |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| mda_active | output | 1 | Monochrome emulation active |
| col80 | output | 1 | Colour 80-column flag |
| gfx_mode | output | 1 | Graphics mode flag |
| video_en | output | 1 | Video and panel power enable |
| cur_start | output | 7 | Cursor start register |
| cur_end | output | 5 | Cursor end register |
| start_hi | output | 8 | Display start address high byte |
| cur_loc | output | 14 | Cursor location |

## Verification
The bench builds the block with its default parameters: 18 register indices, a 5-bit index and a 6-bit high location byte. With these values the index register can be loaded with codes from 18 to 31, which lie beyond the implemented set, so the bench can show that such indices are ignored. The bench also sweeps every 5-bit line number from 0 to 31 through the monochrome rescaling, which covers the values at 12, 13 and above. It walks the start register through 80-column text, 40-column text, graphics and monochrome modes, with the changes of mode occurring while a value is already stored.

// File: rtl/crtc_emu_pkg.sv
package crtc_emu_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    P_INDEX  = 3'd0,
    P_DATA   = 3'd1,
    P_MODE   = 3'd2,
    P_STAT   = 3'd3,
    P_COLSEL = 3'd4
  } port_e;

  localparam int REG_CSTART = 10;
  localparam int REG_CEND   = 11;
  localparam int REG_START  = 12;
  localparam int REG_LOCHI  = 14;
  localparam int REG_LOCLO  = 15;

  localparam logic [7:0] MASK_START80 = 8'h30;
  localparam logic [7:0] MASK_START40 = 8'h38;
  localparam logic [7:0] MASK_MODE    = 8'h3B;
  localparam logic [7:0] STAT_TOGGLE  = 8'h09;

  // rescale a 14-line cell line number into an 8-line cell
  function automatic logic [2:0] scale_line(input logic [4:0] v);
    if (v >= 5'd13)      return 3'd7;
    else if (v == 5'd12) return 3'd6;
    else                 return v[3:1];
  endfunction

endpackage

// File: rtl/crtc_mode_ctl.sv
module crtc_mode_ctl
  import crtc_emu_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_wr,
  input  logic             grp_colour,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] mode_q,
  output logic             mda,
  output logic             col80,
  output logic             gfx,
  output logic             video_en
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      mda    <= 1'b1;
    end else if (mode_wr) begin
      mode_q <= wdata & MASK_MODE;
      mda    <= ~grp_colour;
    end
  end

  assign col80    = mode_q[0];
  assign gfx      = mode_q[1];
  assign video_en = mode_q[3];

  AST_MODE_GROUP: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (mda == !$past(grp_colour))) else $error("mode group");  // R2
  AST_VIDEO_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    mode_wr |=> (video_en == $past(wdata[3]))) else $error("video enable");  // R10

endmodule

// File: rtl/crtc_regs.sv
module crtc_regs
  import crtc_emu_pkg::*;
#(
  parameter int NREG     = 18,
  parameter int LOCHI_W  = 6,
  parameter int SCAN_W   = 5,
  parameter int IDX_W    = $clog2(NREG)
)(
  input  logic               clk,
  input  logic               rst,
  input  logic               idx_wr,
  input  logic               data_wr,
  input  logic [BYTE_W-1:0]  wdata,
  input  logic               mda,
  input  logic               col80,
  input  logic               gfx,
  output logic [IDX_W-1:0]   idx_q,
  output logic [6:0]         cur_start,
  output logic [SCAN_W-1:0]  cur_end,
  output logic [BYTE_W-1:0]  start_hi,
  output logic [LOCHI_W-1:0] loc_hi,
  output logic [BYTE_W-1:0]  loc_lo,
  output logic [BYTE_W-1:0]  rd_val
);

  localparam int PAD_END = BYTE_W - SCAN_W;
  localparam int PAD_LOC = BYTE_W - LOCHI_W;

  logic        hit_cs, hit_ce, hit_st, hit_lh, hit_ll;
  logic [2:0]  scaled;

  assign hit_cs = data_wr && (idx_q == IDX_W'(REG_CSTART));
  assign hit_ce = data_wr && (idx_q == IDX_W'(REG_CEND));
  assign hit_st = data_wr && (idx_q == IDX_W'(REG_START));
  assign hit_lh = data_wr && (idx_q == IDX_W'(REG_LOCHI));
  assign hit_ll = data_wr && (idx_q == IDX_W'(REG_LOCLO));
  assign scaled = scale_line(wdata[4:0]);

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else if (idx_wr) idx_q <= wdata[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_start <= '0;
      cur_end   <= '0;
    end else begin
      if (hit_cs) cur_start <= mda ? {wdata[6:5], 2'b00, scaled} : wdata[6:0];
      if (hit_ce) cur_end   <= mda ? SCAN_W'(scaled) : wdata[SCAN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      start_hi <= '0;
    else if (mda || gfx)
      start_hi <= '0;
    else if (hit_st)
      start_hi <= wdata & (col80 ? MASK_START80 : MASK_START40);
    else if (col80)
      start_hi <= start_hi & MASK_START80;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_hi <= '0;
      loc_lo <= '0;
    end else begin
      if (hit_lh) loc_hi <= wdata[LOCHI_W-1:0];
      if (hit_ll) loc_lo <= wdata;
    end
  end

  always_comb begin
    case (idx_q)
      IDX_W'(REG_CSTART): rd_val = {1'b0, cur_start};
      IDX_W'(REG_CEND):   rd_val = {{PAD_END{1'b0}}, cur_end};
      IDX_W'(REG_START):  rd_val = start_hi;
      IDX_W'(REG_LOCHI):  rd_val = {{PAD_LOC{1'b0}}, loc_hi};
      IDX_W'(REG_LOCLO):  rd_val = loc_lo;
      default:            rd_val = '0;
    endcase
  end

  AST_MDA_LINE_MAX: assert property (@(posedge clk) disable iff (rst)
    (mda && hit_ce) |=> (cur_end <= SCAN_W'(7))) else $error("line range");  // R3
  AST_START_ALIGN: assert property (@(posedge clk) disable iff (rst)
    start_hi[2:0] == 3'b000) else $error("start align");  // R6
  AST_START_80: assert property (@(posedge clk) disable iff (rst)
    (col80 && !mda) |=> (start_hi[3] == 1'b0)) else $error("start 80");  // R5
  AST_START_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (mda || gfx) |=> (start_hi == '0)) else $error("start clear");  // R7
  AST_UNIMPL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !(hit_cs || hit_ce || hit_st || hit_lh || hit_ll))
      |=> ($stable(cur_start) && $stable(cur_end) && $stable(loc_hi) && $stable(loc_lo)))
    else $error("unimpl write");  // R9

endmodule

// File: rtl/crtc_status.sv
module crtc_status
  import crtc_emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              stat_rd,
  output logic [BYTE_W-1:0] stat_val
);

  logic tog;

  always_ff @(posedge clk) begin
    if (rst) tog <= 1'b0;
    else if (stat_rd) tog <= ~tog;
  end

  assign stat_val = tog ? STAT_TOGGLE : '0;

  AST_STAT_FLIP: assert property (@(posedge clk) disable iff (rst)
    stat_rd |=> (stat_val != $past(stat_val))) else $error("status flip");  // R8

endmodule

// File: rtl/crtc_reg_emu.sv
module crtc_reg_emu
  import crtc_emu_pkg::*;
#(
  parameter int NREG    = 18,
  parameter int LOCHI_W = 6,
  parameter int SCAN_W  = 5,
  parameter int IDX_W   = $clog2(NREG),
  parameter int LOC_W   = LOCHI_W + BYTE_W
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [3:0]         io_addr,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic [BYTE_W-1:0]  io_wdata,
  output logic [BYTE_W-1:0]  io_rdata,
  output logic               mda_active,
  output logic               col80,
  output logic               gfx_mode,
  output logic               video_en,
  output logic [6:0]         cur_start,
  output logic [SCAN_W-1:0]  cur_end,
  output logic [BYTE_W-1:0]  start_hi,
  output logic [LOC_W-1:0]   cur_loc
);

  localparam int PAD_IDX = BYTE_W - IDX_W;

  port_e                port;
  logic                 grp_colour;
  logic [BYTE_W-1:0]    mode_q, rd_val, stat_val;
  logic [IDX_W-1:0]     idx_q;
  logic [LOCHI_W-1:0]   loc_hi;
  logic [BYTE_W-1:0]    loc_lo;

  assign port       = port_e'(io_addr[2:0]);
  assign grp_colour = io_addr[3];

  crtc_mode_ctl u_mode (
    .clk(clk), .rst(rst),
    .mode_wr(io_wr && port == P_MODE),
    .grp_colour(grp_colour),
    .wdata(io_wdata),
    .mode_q(mode_q),
    .mda(mda_active),
    .col80(col80),
    .gfx(gfx_mode),
    .video_en(video_en)
  );

  crtc_regs #(.NREG(NREG), .LOCHI_W(LOCHI_W), .SCAN_W(SCAN_W), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst),
    .idx_wr(io_wr && port == P_INDEX),
    .data_wr(io_wr && port == P_DATA),
    .wdata(io_wdata),
    .mda(mda_active),
    .col80(col80),
    .gfx(gfx_mode),
    .idx_q(idx_q),
    .cur_start(cur_start),
    .cur_end(cur_end),
    .start_hi(start_hi),
    .loc_hi(loc_hi),
    .loc_lo(loc_lo),
    .rd_val(rd_val)
  );

  crtc_status u_stat (
    .clk(clk), .rst(rst),
    .stat_rd(io_rd && port == P_STAT),
    .stat_val(stat_val)
  );

  assign cur_loc = {loc_hi, loc_lo};

  always_ff @(posedge clk) begin
    if (rst)
      io_rdata <= '0;
    else if (io_rd) begin
      case (port)
        P_INDEX: io_rdata <= {{PAD_IDX{1'b0}}, idx_q};
        P_DATA:  io_rdata <= rd_val;
        P_MODE:  io_rdata <= mode_q;
        P_STAT:  io_rdata <= stat_val;
        default: io_rdata <= '0;
      endcase
    end
  end

  AST_BW_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (io_rd && port == P_MODE) |=> (io_rdata[2] == 1'b0)) else $error("bw bit");  // R10
  AST_STAT_PATTERN: assert property (@(posedge clk) disable iff (rst)
    (io_rd && port == P_STAT) |=> (io_rdata == 8'h00 || io_rdata == 8'h09))
    else $error("status pattern");  // R8

endmodule

// File: tb/crtc_reg_emu_bench.sv
module crtc_reg_emu_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        mda_active, col80, gfx_mode, video_en;
  logic [6:0]  cur_start;
  logic [4:0]  cur_end;
  logic [7:0]  start_hi;
  logic [13:0] cur_loc;

  int total = 0;
  int bad = 0;
  bit done = 0;

  localparam logic [3:0] M_IDX = 4'h0, M_DAT = 4'h1, M_MODE = 4'h2, M_STAT = 4'h3;
  localparam logic [3:0] C_IDX = 4'h8, C_DAT = 4'h9, C_MODE = 4'hA, C_STAT = 4'hB, C_COLSEL = 4'hC;

  always #4 clk = ~clk;

  crtc_reg_emu u_crtc_reg_emu (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mda_active(mda_active),
    .col80(col80), .gfx_mode(gfx_mode), .video_en(video_en),
    .cur_start(cur_start), .cur_end(cur_end), .start_hi(start_hi), .cur_loc(cur_loc)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0;
    d = io_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int exp_line(input int v);
    case (v)
      0, 1:    return 0;
      2, 3:    return 1;
      4, 5:    return 2;
      6, 7:    return 3;
      8, 9:    return 4;
      10, 11:  return 5;
      12:      return 6;
      default: return 7;
    endcase
  endfunction

  task automatic t_reset();
    logic [7:0] d;
    check("R1 mda", mda_active, 1);
    check("R1 video_en", video_en, 0);
    check("R1 col80", col80, 0);
    check("R1 gfx", gfx_mode, 0);
    check("R1 cur_start", cur_start, 0);
    check("R1 cur_end", cur_end, 0);
    check("R1 start_hi", start_hi, 0);
    check("R1 cur_loc", cur_loc, 0);
    rd(M_STAT, d);
    check("R1 status first read", d, 8'h00);
  endtask

  task automatic t_mda_lines();
    logic [7:0] d;
    wr(M_IDX, 8'd11);
    for (int v = 0; v < 32; v++) begin
      wr(M_DAT, 8'(v));
      check($sformatf("R3 end v=%0d", v), cur_end, exp_line(v));
    end
    wr(M_IDX, 8'd10);
    wr(M_DAT, 8'h2C);
    check("R3 start with high bits", cur_start, 7'h26);
    rd(M_DAT, d);
    check("R12 R3 start readback", d, 8'h26);
    rd(M_IDX, d);
    check("R12 index readback", d, 8'd10);
  endtask

  task automatic t_colour_lines();
    wr(C_MODE, 8'h09);
    check("R2 colour selected", mda_active, 0);
    check("R10 video on", video_en, 1);
    wr(C_IDX, 8'd10);
    wr(C_DAT, 8'h6D);
    check("R4 start raw", cur_start, 7'h6D);
    wr(C_IDX, 8'd11);
    wr(C_DAT, 8'hFD);
    check("R4 end raw", cur_end, 5'h1D);
  endtask

  task automatic t_start_addr();
    logic [7:0] d;
    wr(C_MODE, 8'h09);
    wr(C_IDX, 8'd12);
    wr(C_DAT, 8'h3F);
    check("R5 80col mask", start_hi, 8'h30);
    wr(C_DAT, 8'h1B);
    check("R5 80col mask b", start_hi, 8'h10);
    wr(C_MODE, 8'h08);
    idle(2);
    check("R6 40col keeps", start_hi, 8'h10);
    wr(C_DAT, 8'h2F);
    check("R6 40col mask", start_hi, 8'h28);
    rd(C_DAT, d);
    check("R6 readback", d, 8'h28);
    wr(C_MODE, 8'h09);
    idle(2);
    check("R5 reduce on entry", start_hi, 8'h20);
    wr(C_MODE, 8'h0A);
    idle(2);
    check("R7 gfx clears", start_hi, 8'h00);
    wr(C_DAT, 8'h18);
    idle(2);
    check("R7 gfx write ignored", start_hi, 8'h00);
    wr(C_MODE, 8'h08);
    wr(C_DAT, 8'h18);
    check("R6 back to text", start_hi, 8'h18);
    wr(M_MODE, 8'h08);
    idle(2);
    check("R7 mda clears", start_hi, 8'h00);
    check("R2 mono selected", mda_active, 1);
    wr(M_IDX, 8'd12);
    wr(M_DAT, 8'h10);
    idle(2);
    rd(M_DAT, d);
    check("R7 mda write ignored", d, 8'h00);
  endtask

  task automatic t_location();
    logic [7:0] d;
    wr(M_IDX, 8'd14);
    wr(M_DAT, 8'hFF);
    wr(M_IDX, 8'd15);
    wr(M_DAT, 8'hA5);
    check("R11 loc mono", cur_loc, 14'h3FA5);
    wr(C_MODE, 8'h08);
    wr(C_IDX, 8'd14);
    wr(C_DAT, 8'h12);
    check("R11 loc colour", cur_loc, 14'h12A5);
    rd(C_DAT, d);
    check("R11 loc hi readback", d, 8'h12);
  endtask

  task automatic t_unimpl();
    logic [7:0] d;
    logic [6:0] cs;
    logic [4:0] ce;
    logic [13:0] cl;
    cs = cur_start; ce = cur_end; cl = cur_loc;
    wr(C_IDX, 8'd13);
    wr(C_DAT, 8'h55);
    rd(C_DAT, d);
    check("R9 read idx13", d, 8'h00);
    wr(C_IDX, 8'd20);
    wr(C_DAT, 8'hFF);
    rd(C_DAT, d);
    check("R9 read idx20", d, 8'h00);
    wr(C_IDX, 8'd0);
    wr(C_DAT, 8'h77);
    check("R9 cur_start held", cur_start, cs);
    check("R9 cur_end held", cur_end, ce);
    check("R9 cur_loc held", cur_loc, cl);
    check("R9 start held", start_hi, 8'h00);
  endtask

  task automatic t_mode_port();
    logic [7:0] d;
    wr(C_MODE, 8'h0D);
    rd(C_MODE, d);
    check("R10 bw bit cleared", d, 8'h09);
    wr(C_COLSEL, 8'hFF);
    rd(C_MODE, d);
    check("R10 colsel no effect", d, 8'h09);
    check("R10 colsel mode flags", {video_en, gfx_mode, col80, mda_active}, 4'b1010);
    wr(C_MODE, 8'h01);
    check("R10 video off", video_en, 0);
  endtask

  task automatic t_status();
    logic [7:0] d0, d1, d2;
    rd(C_STAT, d0);
    rd(M_STAT, d1);
    rd(C_STAT, d2);
    check("R8 pattern", (d0 == 8'h00 || d0 == 8'h09) ? 1 : 0, 1);
    check("R8 flip", d1, d0 ^ 8'h09);
    check("R8 flip back", d2, d0);
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_mda_lines();
    t_colour_lines();
    t_start_addr();
    t_location();
    t_unimpl();
    t_mode_port();
    t_status();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule